// File: doc/BRIEF.md
# Open-Row DRAM Bank Controller

A behavioural model of a multi-bank DRAM with a command front end. One request at a time is taken over a valid/ready handshake. It carries a 31-bit address, a read/write flag and, for writes, one data byte. The address is split into a bank-group field, a bank field, a row field and a column field. Bank group and bank together pick one of 32 banks. Each bank keeps at most one open row in a row buffer, which stands in for the sense amplifiers.

An access to a bank with no open row runs three phases: precharge, then activate (the selected row is loaded from the cell array into the row buffer), then column access. When the requested row is already open (a page hit), only the column access runs. When a different row is open (a row miss), the old row is written back to the array and closed during precharge, and the new row is then activated. Each phase takes a parameterised number of cycles.

A read returns one byte with a single-cycle response pulse. A write replaces one byte in both the row buffer and the array. To keep the storage small, the cell array holds only the low row and column index bits. Rows and columns that differ only in higher bits share storage, but a page hit is decided on the full 16-bit row field.

Top module: `dram_bank_ctrl`

## Requirements
- R1: The address fields are: bank index = `req_addr[30:26]` (bank group `[30:28]` above bank `[27:26]`), row = `req_addr[25:10]`, column = `req_addr[9:0]`. The array is indexed by the low `ROW_IDX_BITS` of the row and the low `COL_IDX_BITS` of the column.
- R2: After reset, `req_ready` is 1, `rsp_valid` is 0, every bank is closed and every array byte reads as 0.
- R3: An access to a closed bank completes `T_PRE+T_ACT+T_COL` cycles after the accepting clock edge. It passes through precharge, then activate, then column access.
- R4: An access whose row equals the open row of its bank (a page hit) completes `T_COL` cycles after acceptance, skipping precharge and activate.
- R5: An access to a different row in a bank with an open row (a row miss) completes `T_PRE+T_ACT+T_COL` cycles after acceptance. It writes the old row back, closes it, and opens the new row, so that the column access sees the new row's stored contents.
- R6: A write replaces bits `[8c+7:8c]` of the selected row, where c is the column index, in both the row buffer and the array. The other bytes stay unchanged.
- R7: A read completes with `rsp_valid` high for exactly one cycle, with `rsp_rdata` holding the addressed byte.
- R8: `req_ready` is low from the cycle after acceptance until completion. A request presented during that time is not taken.
- R9: Activity on one bank leaves the open state and row buffer of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 31 | Bank group, bank, row, column |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse when read data is valid |
| rsp_rdata | output | 8 | Read byte |

## Verification
The bench uses the default parameters: precharge 2, activate 3 and column access 2 cycles. These give a 2-cycle hit against a 7-cycle closed or miss access, so a skipped or repeated phase shows as a wrong latency. With four rows of four bytes per bank, a write, a row miss to a neighbouring row and a reopen all fit in a few requests, which makes write-back and byte isolation visible through reads. The test also reaches the highest bank and the all-ones row and column fields.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    localparam int ADDR_W     = 31;
    localparam int GRP_W      = 3;
    localparam int BNK_W      = 2;
    localparam int ROW_W      = 16;
    localparam int COL_W      = 10;
    localparam int BANK_IDX_W = GRP_W + BNK_W;
    localparam int NUM_BANKS  = 1 << BANK_IDX_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_ACT  = 2'd2,
        PH_COL  = 2'd3
    } phase_e;

    typedef struct packed {
        logic                  is_write;
        logic [BANK_IDX_W-1:0] bank;
        logic [ROW_W-1:0]      row;
        logic [COL_W-1:0]      col;
        logic [7:0]            data;
    } dram_req_t;

    function automatic dram_req_t decode_req(input logic [ADDR_W-1:0] addr,
                                             input logic wr,
                                             input logic [7:0] wdata);
        dram_req_t r;
        r.is_write = wr;
        r.bank     = addr[ADDR_W-1 -: BANK_IDX_W];
        r.row      = addr[COL_W +: ROW_W];
        r.col      = addr[COL_W-1:0];
        r.data     = wdata;
        return r;
    endfunction

endpackage

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
    parameter int NUM_BANKS    = 32,
    parameter int ROW_IDX_BITS = 2,
    parameter int LINE_W       = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(NUM_BANKS)-1:0] rd_bank,
    input  logic [ROW_IDX_BITS-1:0]      rd_row,
    output logic [LINE_W-1:0]            rd_line,
    input  logic                         we,
    input  logic [$clog2(NUM_BANKS)-1:0] wr_bank,
    input  logic [ROW_IDX_BITS-1:0]      wr_row,
    input  logic [LINE_W-1:0]            wr_line
);
    localparam int DEPTH = NUM_BANKS << ROW_IDX_BITS;

    logic [LINE_W-1:0] cells [DEPTH];

    assign rd_line = cells[{rd_bank, rd_row}];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[{wr_bank, wr_row}] <= wr_line;
        end
    end
endmodule

// File: rtl/dram_open_rows.sv
module dram_open_rows #(
    parameter int NUM_BANKS = 32,
    parameter int ROW_W     = 16,
    parameter int LINE_W    = 32,
    parameter int COL_IDX_W = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(NUM_BANKS)-1:0] sel,
    output logic                         open_o,
    output logic [ROW_W-1:0]             tag_o,
    output logic [LINE_W-1:0]            line_o,
    input  logic                         close_i,
    input  logic                         load_i,
    input  logic [ROW_W-1:0]             load_tag_i,
    input  logic [LINE_W-1:0]            load_line_i,
    input  logic                         bw_i,
    input  logic [COL_IDX_W-1:0]         bw_idx_i,
    input  logic [7:0]                   bw_data_i
);
    logic [NUM_BANKS-1:0] open_q;
    logic [ROW_W-1:0]     tag_q  [NUM_BANKS];
    logic [LINE_W-1:0]    line_q [NUM_BANKS];
    logic                 rst_d;

    assign open_o = open_q[sel];
    assign tag_o  = tag_q[sel];
    assign line_o = line_q[sel];

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            open_q <= '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                tag_q[b]  <= '0;
                line_q[b] <= '0;
            end
        end else begin
            if (close_i) open_q[sel] <= 1'b0;
            if (load_i) begin
                open_q[sel] <= 1'b1;
                tag_q[sel]  <= load_tag_i;
                line_q[sel] <= load_line_i;
            end
            if (bw_i) line_q[sel][{bw_idx_i, 3'b000} +: 8] <= bw_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && rst_d)
            AST_RESET_CLOSED: assert (open_q == '0) else $error("banks open after reset"); // R2
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_iso
        AST_BANK_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            (sel != b) |=> ($stable(open_q[b]) && $stable(line_q[b]))); // R9
    end
endmodule

// File: rtl/dram_phase_seq.sv
module dram_phase_seq
    import dram_ctrl_pkg::*;
#(
    parameter int T_PRE = 2,
    parameter int T_ACT = 3,
    parameter int T_COL = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   hit_i,
    output phase_e phase_o,
    output logic   last_o
);
    localparam int T_MAX = (T_PRE > T_ACT) ? ((T_PRE > T_COL) ? T_PRE : T_COL)
                                           : ((T_ACT > T_COL) ? T_ACT : T_COL);
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] C_PRE = CNT_W'(T_PRE - 1);
    localparam logic [CNT_W-1:0] C_ACT = CNT_W'(T_ACT - 1);
    localparam logic [CNT_W-1:0] C_COL = CNT_W'(T_COL - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;

    assign phase_o = phase_q;
    assign last_o  = (phase_q != PH_IDLE) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (start_i) begin
                phase_q <= hit_i ? PH_COL : PH_PRE;
                cnt_q   <= hit_i ? C_COL : C_PRE;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            unique case (phase_q)
                PH_PRE:  begin phase_q <= PH_ACT;  cnt_q <= C_ACT; end
                PH_ACT:  begin phase_q <= PH_COL;  cnt_q <= C_COL; end
                default: begin phase_q <= PH_IDLE; cnt_q <= '0;    end
            endcase
        end
    end

    AST_ACT_AFTER_PRE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ACT && $past(phase_q) != PH_ACT) |-> ($past(phase_q) == PH_PRE)); // R3
endmodule

// File: rtl/dram_bank_ctrl.sv
module dram_bank_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int T_PRE        = 2,
    parameter int T_ACT        = 3,
    parameter int T_COL        = 2,
    parameter int ROW_IDX_BITS = 2,
    parameter int COL_IDX_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_wdata,
    output logic              rsp_valid,
    output logic [7:0]        rsp_rdata
);
    localparam int LINE_W = 8 << COL_IDX_BITS;

    dram_req_t             in_req, req_q;
    phase_e                phase;
    logic                  last, accept, hit;
    logic [BANK_IDX_W-1:0] sel_bank;
    logic                  row_open;
    logic [ROW_W-1:0]      row_tag;
    logic [LINE_W-1:0]     row_line, arr_line, merged, wr_line;
    logic                  pre_end, act_end, col_end, arr_we;
    logic [COL_IDX_BITS-1:0] col_idx;

    assign in_req    = decode_req(req_addr, req_write, req_wdata);
    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign sel_bank  = req_ready ? in_req.bank : req_q.bank;
    assign hit       = row_open && (row_tag == in_req.row);
    assign pre_end   = (phase == PH_PRE) && last;
    assign act_end   = (phase == PH_ACT) && last;
    assign col_end   = (phase == PH_COL) && last;
    assign col_idx   = req_q.col[COL_IDX_BITS-1:0];
    assign arr_we    = (pre_end && row_open) || (col_end && req_q.is_write);
    assign wr_line   = pre_end ? row_line : merged;

    always_comb begin
        merged = row_line;
        merged[{col_idx, 3'b000} +: 8] = req_q.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) req_q <= in_req;
            rsp_valid <= col_end && !req_q.is_write;
            if (col_end && !req_q.is_write) rsp_rdata <= row_line[{col_idx, 3'b000} +: 8];
        end
    end

    dram_phase_seq #(.T_PRE(T_PRE), .T_ACT(T_ACT), .T_COL(T_COL)) u_seq (
        .clk(clk), .rst(rst), .start_i(accept), .hit_i(hit),
        .phase_o(phase), .last_o(last)
    );

    dram_open_rows #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .LINE_W(LINE_W),
                     .COL_IDX_W(COL_IDX_BITS)) u_rows (
        .clk(clk), .rst(rst), .sel(sel_bank),
        .open_o(row_open), .tag_o(row_tag), .line_o(row_line),
        .close_i(pre_end), .load_i(act_end), .load_tag_i(req_q.row), .load_line_i(arr_line),
        .bw_i(col_end && req_q.is_write), .bw_idx_i(col_idx), .bw_data_i(req_q.data)
    );

    dram_cell_array #(.NUM_BANKS(NUM_BANKS), .ROW_IDX_BITS(ROW_IDX_BITS),
                      .LINE_W(LINE_W)) u_cells (
        .clk(clk), .rst(rst),
        .rd_bank(req_q.bank), .rd_row(req_q.row[ROW_IDX_BITS-1:0]), .rd_line(arr_line),
        .we(arr_we), .wr_bank(req_q.bank), .wr_row(row_tag[ROW_IDX_BITS-1:0]), .wr_line(wr_line)
    );

    AST_HIT_SKIPS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> (phase == PH_COL)); // R4
    AST_COL_ROW_OPEN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COL) |-> (row_open && row_tag == req_q.row)); // R5
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R8
endmodule

// File: tb/dram_bank_ctrl_bench.sv
module dram_bank_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LAT_HIT  = 2;
    localparam int LAT_FULL = 7;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [30:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;

    int n_checks = 0, n_fail = 0;
    int lat;
    logic [7:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_bank_ctrl u_dram_bank_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // {write, bank[4:0], row[15:0], col[9:0], wdata, expected latency[3:0], expected read byte}
    // R1: address = {bank, row, col}
    localparam logic [51:0] VEC [12] = '{
        {1'b1, 5'd5,  16'h0010, 10'd1,   8'hA5, 4'd7, 8'h00},  // closed bank, R3
        {1'b0, 5'd5,  16'h0010, 10'd1,   8'h00, 4'd2, 8'hA5},  // hit
        {1'b1, 5'd5,  16'h0010, 10'd2,   8'h3C, 4'd2, 8'h00},  // hit write
        {1'b0, 5'd5,  16'h0011, 10'd1,   8'h00, 4'd7, 8'h00},  // row miss
        {1'b0, 5'd5,  16'h0010, 10'd2,   8'h00, 4'd7, 8'h3C},  // miss back, R5
        {1'b1, 5'd9,  16'h0010, 10'd1,   8'h77, 4'd7, 8'h00},  // other bank
        {1'b0, 5'd5,  16'h0010, 10'd1,   8'h00, 4'd2, 8'hA5},  // R9 bank 5 still open
        {1'b0, 5'd9,  16'h0010, 10'd1,   8'h00, 4'd2, 8'h77},
        {1'b0, 5'd9,  16'h0010, 10'd0,   8'h00, 4'd2, 8'h00},  // R6 neighbour byte
        {1'b1, 5'd31, 16'hFFFF, 10'h3FF, 8'hFF, 4'd7, 8'h00},  // all-ones fields
        {1'b0, 5'd31, 16'hFFFF, 10'h3FF, 8'h00, 4'd2, 8'hFF},
        {1'b0, 5'd31, 16'hFFFF, 10'd2,   8'h00, 4'd2, 8'h00}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issues one request; hold_busy keeps req_valid high during the busy period.
    task automatic run_req(input logic w, input logic [4:0] bank, input logic [15:0] row,
                           input logic [9:0] col, input logic [7:0] d, input logic hold_busy);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = {bank, row, col}; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        if (hold_busy) begin
            req_write = 1'b1; req_addr = {bank, row, 10'd0}; req_wdata = 8'hEE;
        end else begin
            req_valid = 1'b0;
        end
        lat = 0; guard = 0; got = 8'h00;
        while (guard < 40) begin
            guard++;
            if (w ? req_ready : rsp_valid) break;
            check("R8 ready low while busy", int'(req_ready), 0);
            @(posedge clk); lat++;
            @(negedge clk);
            if (w ? req_ready : rsp_valid) begin
                got = rsp_rdata;
                break;
            end
        end
        req_valid = 1'b0;
        if (!w) begin
            @(posedge clk); @(negedge clk);
            check("R7 rsp_valid single cycle", int'(rsp_valid), 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 req_ready after reset", int'(req_ready), 1);
        check("R2 rsp_valid after reset", int'(rsp_valid), 0);
        rst = 1'b0;

        foreach (VEC[i]) begin
            logic [51:0] v;
            v = VEC[i];
            run_req(v[51], v[50:46], v[45:30], v[29:20], v[19:12], 1'b0);
            check((int'(v[11:8]) == LAT_HIT) ? "R4 hit latency" : "R3/R5 open latency",
                  lat, int'(v[11:8]));
            if (!v[51]) check("R6/R7 read byte", int'(got), int'(v[7:0]));
        end

        // R8: a request held during busy is not taken
        run_req(1'b0, 5'd3, 16'h0002, 10'd1, 8'h00, 1'b1);
        check("R8 closed read latency", lat, LAT_FULL);
        run_req(1'b0, 5'd3, 16'h0002, 10'd0, 8'h00, 1'b0);
        check("R8 held write not taken", int'(got), 0);
        check("R8 follow-up is hit", lat, LAT_HIT);

        // R2: reset mid-run closes all banks and clears the array
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check("R2 ready after second reset", int'(req_ready), 1);
        run_req(1'b0, 5'd5, 16'h0010, 10'd1, 8'h00, 1'b0);
        check("R2 bank closed after reset", lat, LAT_FULL);
        check("R2 array cleared", int'(got), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R8 cycles=20000 expected=fewer");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule